// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive half of a network DMA engine. Incoming frames arrive as a byte stream with start and end markers; the block takes a buffer descriptor from a ring in memory, checks that software has handed it over, writes the frame bytes into the buffer and then writes back a status word and the ownership flag. Software walks the same ring, reads the status of each completed descriptor and returns it by clearing the ownership flag.

Each descriptor is two 32-bit words at consecutive addresses. The first word holds the buffer address, a ring-end marker and the ownership flag. The second word holds the frame-boundary flags and the length. The block talks to memory through a simple single-beat port. Reads return data one cycle after the request. A frame longer than one buffer spills into the following descriptors. A descriptor still owned by software causes the rest of the frame to be dropped.

Top module: `rx_ring_writer`

## Requirements
- R1: On a byte carrying the start marker while enabled, the block reads the first word of the current descriptor before it accepts any byte of the frame. `s_ready_o` stays low until that word has been checked. Descriptors are 8 bytes. In word 0, bits 31:2 are the buffer address, bit 1 marks the last descriptor of the ring and bit 0 is the ownership flag (1 = owned by software). Word 1 is the status word.
- R2: Frame byte n of a buffer is written at buffer address + n, in byte lane n mod 4 of a 32-bit word. Byte enables are set only for lanes that carry frame bytes. Bytes past the end of the frame are left untouched.
- R3: When a buffer is closed, the status word is written first and word 0 second. In the status word, bit 15 is the end flag, bit 14 is the start flag and bits 13:0 are the length; all other bits are 0. Word 0 is then rewritten with bit 0 set and with its address and ring-end bits unchanged.
- R4: After a descriptor is closed, the pointer moves on by 8 bytes. If the closed descriptor had its ring-end bit set, the pointer returns to `queue_base_i` instead.
- R5: If the fetched word 0 has bit 0 set, the block consumes and discards the remaining bytes of the frame up to the end marker. It writes nothing to memory, pulses `bna_o` high for exactly one cycle and leaves the pointer on the same descriptor.
- R6: A frame longer than BUF_BYTES continues into the next descriptor. Only the first descriptor carries the start flag. Only the last carries the end flag and the total frame length. Non-final descriptors report length 0.
- R7: While `rx_en_i` is low, stream bytes are accepted and discarded, no memory access is made and the pointer is held at `queue_base_i`.
- R8: During and after reset, `mem_req_o` and `bna_o` are low.
- R9: A byte without the start marker that arrives while the block waits for a frame is accepted and discarded, with no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive enable |
| queue_base_i | input | 32 | Byte address of the first descriptor of the ring |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_sof_i | input | 1 | Byte is the first of a frame |
| s_eof_i | input | 1 | Byte is the last of a frame |
| s_ready_o | output | 1 | Stream byte accepted this cycle when high together with valid |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write (1) or read (0) |
| mem_addr_o | output | 32 | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_be_o | output | 4 | Byte enables for writes |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read request |
| bna_o | output | 1 | One-cycle pulse when a frame is dropped for lack of a free descriptor |

## Verification
The tests use several input patterns, and each one separates one behaviour from the others:
- A short frame that ends mid-word, after a stray unmarked byte, separates correct byte-lane packing and partial enables from whole-word writes. Its write count shows that the stray byte was ignored.
- A frame longer than one buffer shows whether the start and end flags and the length are split correctly across descriptors.
- Frames that land on the ring-end descriptor and then on a descriptor still owned by software tell a wrap back to the base apart from a plain increment. They also tell a drop apart from an overwrite.
- A frame sent while disabled, followed by re-enabling, shows that the pointer returns to the base and that no memory traffic leaks out.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int DW       = 32;
  localparam int LEN_W    = 14;
  localparam int DESC_B   = 8;
  localparam int USED_BIT = 0;
  localparam int WRAP_BIT = 1;
  localparam int SOF_BIT  = 14;
  localparam int EOF_BIT  = 15;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_DATA, S_STS, S_OWN, S_DROP
  } rxr_state_e;
endpackage

// File: rtl/rxr_byte_packer.sv
module rxr_byte_packer #(
  parameter int BUF_BYTES = 1536,
  localparam int CNT_W = $clog2(BUF_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             take_i,
  input  logic [7:0]       byte_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [31:0]      wdata_o,
  output logic [3:0]       be_o,
  output logic             last_o
);
  logic [31:0]      acc_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       lane;

  assign lane   = cnt_q[1:0];
  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == CNT_W'(BUF_BYTES - 1));

  always_comb begin
    wdata_o = acc_q;
    wdata_o[8*lane +: 8] = byte_i;
  end

  for (genvar i = 0; i < 4; i++) begin : g_be
    assign be_o[i] = (2'(i) <= lane);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (take_i) begin
      acc_q <= wdata_o;
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [31:0] base_i,
  input  logic        step_i,
  input  logic        wrap_i,
  output logic [31:0] ptr_o
);
  import rxr_pkg::*;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_o <= '0;
    else if (load_i)  ptr_o <= base_i;
    else if (step_i)  ptr_o <= wrap_i ? base_i : ptr_o + 32'(DESC_B);
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int BUF_BYTES = 1536,
  localparam int CNT_W = $clog2(BUF_BYTES)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_en_i,
  input  logic [31:0] queue_base_i,
  input  logic        s_valid_i,
  input  logic [7:0]  s_data_i,
  input  logic        s_sof_i,
  input  logic        s_eof_i,
  output logic        s_ready_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  output logic [3:0]  mem_be_o,
  input  logic [31:0] mem_rdata_i,
  output logic        bna_o
);
  import rxr_pkg::*;

  rxr_state_e       state_q;
  logic [31:0]      buf_base_q, ptr;
  logic             wrap_q, first_q, eof_q, bna_q;
  logic [LEN_W-1:0] tot_len_q;
  logic             accept, take, need_wr, req;
  logic [CNT_W-1:0] pk_cnt;
  logic [31:0]      pk_wdata, byte_off;
  logic [3:0]       pk_be;
  logic             pk_last, pk_clr, step;

  assign accept = s_valid_i && s_ready_o;
  assign take   = (state_q == S_DATA) && accept;
  assign pk_clr = (state_q == S_CHECK);
  assign step   = (state_q == S_OWN);
  assign bna_o  = bna_q;

  rxr_byte_packer #(.BUF_BYTES(BUF_BYTES)) u_pack (
    .clk_i, .rst_ni, .clr_i(pk_clr), .take_i(take), .byte_i(s_data_i),
    .cnt_o(pk_cnt), .wdata_o(pk_wdata), .be_o(pk_be), .last_o(pk_last)
  );

  rxr_ring_ptr u_ptr (
    .clk_i, .rst_ni, .load_i(!rx_en_i), .base_i(queue_base_i),
    .step_i(step), .wrap_i(wrap_q), .ptr_o(ptr)
  );

  assign byte_off = {{(32-CNT_W){1'b0}}, pk_cnt[CNT_W-1:2], 2'b00};
  assign need_wr  = take && (pk_be[3] || s_eof_i || pk_last);

  always_comb begin
    case (state_q)
      S_IDLE:  s_ready_o = !(s_sof_i && rx_en_i);
      S_DATA,
      S_DROP:  s_ready_o = 1'b1;
      default: s_ready_o = 1'b0;
    endcase
  end

  always_comb begin
    req         = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = ptr;
    mem_wdata_o = '0;
    mem_be_o    = 4'hf;
    case (state_q)
      S_FETCH: req = 1'b1;
      S_DATA: begin
        req         = need_wr;
        mem_we_o    = 1'b1;
        mem_addr_o  = buf_base_q + byte_off;
        mem_wdata_o = pk_wdata;
        mem_be_o    = pk_be;
      end
      S_STS: begin
        req         = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = ptr + 32'd4;
        mem_wdata_o[EOF_BIT]     = eof_q;
        mem_wdata_o[SOF_BIT]     = first_q;
        mem_wdata_o[LEN_W-1:0]   = eof_q ? tot_len_q : '0;
      end
      S_OWN: begin
        req         = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = {buf_base_q[31:2], wrap_q, 1'b1};
      end
      default: ;
    endcase
  end
  assign mem_req_o = req && rx_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      buf_base_q <= '0;
      wrap_q     <= 1'b0;
      first_q    <= 1'b0;
      eof_q      <= 1'b0;
      bna_q      <= 1'b0;
      tot_len_q  <= '0;
    end else begin
      bna_q <= 1'b0;
      if (take) tot_len_q <= tot_len_q + LEN_W'(1);
      if (!rx_en_i) begin
        state_q <= S_IDLE;
      end else begin
        case (state_q)
          S_IDLE: if (s_valid_i && s_sof_i) begin
            state_q   <= S_FETCH;
            first_q   <= 1'b1;
            tot_len_q <= '0;
          end
          S_FETCH: state_q <= S_CHECK;
          S_CHECK: begin
            if (mem_rdata_i[USED_BIT]) begin
              state_q <= S_DROP;
              bna_q   <= 1'b1;
            end else begin
              state_q    <= S_DATA;
              buf_base_q <= {mem_rdata_i[31:2], 2'b00};
              wrap_q     <= mem_rdata_i[WRAP_BIT];
            end
          end
          S_DATA: if (take && (s_eof_i || pk_last)) begin
            state_q <= S_STS;
            eof_q   <= s_eof_i;
          end
          S_STS: state_q <= S_OWN;
          S_OWN: begin
            state_q <= eof_q ? S_IDLE : S_FETCH;
            first_q <= 1'b0;
          end
          S_DROP: if (accept && s_eof_i) state_q <= S_IDLE;
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
  parameter int BUF_BYTES = 1536
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                rx_en_i,
  input logic [31:0]         queue_base_i,
  input logic                s_ready_o,
  input logic                mem_req_o,
  input logic                mem_we_o,
  input logic [31:0]         mem_addr_o,
  input logic                bna_o,
  input rxr_pkg::rxr_state_e state_q,
  input logic [31:0]         ptr,
  input logic [31:0]         buf_base_q,
  input logic                wrap_q
);
  import rxr_pkg::*;

  // R1: word 0 read at the pointer in the cycle before the check
  p_fetch_at_ptr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_CHECK |-> $past(mem_req_o && !mem_we_o && mem_addr_o == ptr));

  p_no_ready_in_desc_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_FETCH || state_q == S_CHECK || state_q == S_STS || state_q == S_OWN)
    |-> !s_ready_o);

  p_data_in_buffer_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DATA && mem_req_o) |-> (mem_addr_o - buf_base_q) < 32'(BUF_BYTES));

  p_status_before_own_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_OWN |-> $past(state_q) == S_STS);

  p_wrap_to_base_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_OWN && rx_en_i && wrap_q) |=> ptr == $past(queue_base_i));

  p_bna_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bna_o |=> !bna_o);

  p_off_goes_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> state_q == S_IDLE);
endmodule

bind rx_ring_writer rxr_checker #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk_i, .rst_ni, .rx_en_i, .queue_base_i, .s_ready_o, .mem_req_o, .mem_we_o,
  .mem_addr_o, .bna_o, .state_q, .ptr, .buf_base_q, .wrap_q
);

// File: tb/tb_rx_ring_writer.sv
`timescale 1ns/1ps
module tb_rx_ring_writer;
  localparam int BUF = 16;
  localparam logic [31:0] QBASE = 32'h100;

  logic clk = 1'b0, rst_ni = 1'b0, rx_en = 1'b0;
  logic s_valid = 1'b0, s_sof = 1'b0, s_eof = 1'b0;
  logic [7:0] s_data = '0;
  logic s_ready, mem_req, mem_we, bna;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;

  int tests = 0, fails = 0, wr_cnt = 0, bna_cnt = 0;
  logic [31:0] mem [0:511];

  always #5 clk = ~clk;

  rx_ring_writer #(.BUF_BYTES(BUF)) dut (
    .clk_i(clk), .rst_ni, .rx_en_i(rx_en), .queue_base_i(QBASE),
    .s_valid_i(s_valid), .s_data_i(s_data), .s_sof_i(s_sof), .s_eof_i(s_eof),
    .s_ready_o(s_ready), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_be_o(mem_be),
    .mem_rdata_i(mem_rdata), .bna_o(bna)
  );

  always @(posedge clk) begin
    if (bna) bna_cnt++;
    if (mem_req) begin
      if (mem_we) begin
        wr_cnt++;
        for (int i = 0; i < 4; i++)
          if (mem_be[i]) mem[mem_addr[10:2]][8*i +: 8] = mem_wdata[8*i +: 8];
      end else mem_rdata <= mem[mem_addr[10:2]];
    end
  end

  function automatic logic [7:0] rd_byte(input logic [31:0] a);
    return mem[a[10:2]][8*a[1:0] +: 8];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic init_ring();
    for (int i = 0; i < 4; i++) begin
      mem[(QBASE[10:2]) + 2*i]     = 32'h400 + 32'(i) * 32'h40 + (i == 3 ? 32'h2 : 32'h0);
      mem[(QBASE[10:2]) + 2*i + 1] = '0;
    end
    for (int a = 32'h400; a < 32'h500; a += 4) mem[a[10:2]] = 32'hEEEEEEEE;
  endtask

  task automatic send_byte(input logic [7:0] d, input bit sof, input bit eof);
    @(negedge clk);
    s_valid = 1'b1; s_data = d; s_sof = sof; s_eof = eof;
    #1;
    while (!s_ready) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic send_frame(input int n, input logic [7:0] seed);
    for (int k = 0; k < n; k++) send_byte(seed + 8'(k), k == 0, k == n - 1);
    @(negedge clk);
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk_eq("R8 req in reset", 32'(mem_req), 0);
    chk_eq("R8 bna in reset", 32'(bna), 0);
    @(negedge clk); rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk_eq("R8 req after reset", 32'(mem_req), 0);
    chk_eq("R8 bna after reset", 32'(bna), 0);
  endtask

  task automatic t_single();
    int w0;
    rx_en = 1'b1;
    repeat (2) @(negedge clk);
    w0 = wr_cnt;
    send_byte(8'h77, 1'b0, 1'b0);  // stray byte, R9
    send_frame(6, 8'h10);
    chk_eq("R9 stray byte costs no write", 32'(wr_cnt - w0), 4);
    chk_eq("R3 word0 used set", mem[QBASE[10:2]], 32'h401);
    chk_eq("R3 status sof eof len", mem[QBASE[10:2] + 1], 32'h0000C006);
    for (int k = 0; k < 6; k++) chk_eq("R2 byte", 32'(rd_byte(32'h400 + 32'(k))), 32'h10 + 32'(k));
    chk_eq("R2 tail untouched", 32'(rd_byte(32'h406)), 32'hEE);
    chk_eq("R1 no bna", 32'(bna_cnt), 0);
  endtask

  task automatic t_multi();
    send_frame(20, 8'h40);
    chk_eq("R6 first desc word0", mem[QBASE[10:2] + 2], 32'h441);
    chk_eq("R6 first desc status", mem[QBASE[10:2] + 3], 32'h00004000);
    chk_eq("R6 last desc word0", mem[QBASE[10:2] + 4], 32'h481);
    chk_eq("R6 last desc status", mem[QBASE[10:2] + 5], 32'h00008014);
    chk_eq("R6 byte 15", 32'(rd_byte(32'h44F)), 32'h4F);
    chk_eq("R6 byte 19", 32'(rd_byte(32'h483)), 32'h53);
    chk_eq("R2 second buffer tail", mem[32'h484 >> 2], 32'hEEEEEEEE);
  endtask

  task automatic t_wrap();
    mem[32'h120 >> 2] = 32'h12345678;
    send_frame(3, 8'h80);
    chk_eq("R4 ring end word0 keeps wrap", mem[QBASE[10:2] + 6], 32'h4C3);
    chk_eq("R4 ring end status", mem[QBASE[10:2] + 7], 32'h0000C003);
    mem[QBASE[10:2]] = 32'h400;  // software returns desc 0
    send_frame(2, 8'h90);
    chk_eq("R4 wrapped to base byte", 32'(rd_byte(32'h400)), 32'h90);
    chk_eq("R4 wrapped word0", mem[QBASE[10:2]], 32'h401);
    chk_eq("R4 wrapped status", mem[QBASE[10:2] + 1], 32'h0000C002);
    chk_eq("R4 past ring untouched", mem[32'h120 >> 2], 32'h12345678);
  endtask

  task automatic t_bna();
    int w0, b0;
    w0 = wr_cnt; b0 = bna_cnt;
    send_frame(5, 8'hA0);  // desc 1 still owned by software
    chk_eq("R5 one bna pulse", 32'(bna_cnt - b0), 1);
    chk_eq("R5 no writes", 32'(wr_cnt - w0), 0);
    chk_eq("R5 status kept", mem[QBASE[10:2] + 3], 32'h00004000);
    chk_eq("R5 buffer kept", 32'(rd_byte(32'h440)), 32'h40);
    mem[QBASE[10:2] + 2] = 32'h440;
    send_frame(4, 8'hB0);
    chk_eq("R5 pointer held on desc1", 32'(rd_byte(32'h440)), 32'hB0);
    chk_eq("R5 desc1 status", mem[QBASE[10:2] + 3], 32'h0000C004);
  endtask

  task automatic t_disable();
    int w0;
    @(negedge clk); rx_en = 1'b0;
    w0 = wr_cnt;
    send_frame(3, 8'hD0);
    chk_eq("R7 no memory traffic while off", 32'(wr_cnt - w0), 0);
    init_ring();
    @(negedge clk); rx_en = 1'b1;
    send_frame(2, 8'hC0);
    chk_eq("R7 restart at base byte", 32'(rd_byte(32'h400)), 32'hC0);
    chk_eq("R7 restart word0", mem[QBASE[10:2]], 32'h401);
    chk_eq("R7 desc2 untouched", mem[QBASE[10:2] + 5], 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = '0;
    mem_rdata = '0;
    init_ring();
    t_reset();
    t_single();
    t_multi();
    t_wrap();
    t_bna();
    t_disable();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule